// File: doc/BRIEF.md
# Integer Shift, Subtract and Exclusive-OR Execute Unit

This unit is one execute slice of a 32-bit integer datapath. Each cycle it takes the two source operands, the constant shift-amount field, the 16-bit immediate, the primary opcode and the function field of one instruction. One clock edge later it presents the computed result, a trap flag for signed-subtract overflow, a flag for an encoding it does not implement, and a write enable. The write enable tells the writeback logic whether the result may be committed.

The unit handles four groups of operations:
- Right shifts that fill with zeros or with copies of the sign bit. The amount is either the constant field or the low five bits of the first source operand.
- Subtraction of the second source from the first, with or without an overflow trap.
- Bitwise exclusive-OR with the second source.
- Bitwise exclusive-OR with a zero-extended immediate.

Operands come from outside, and the register file and pipeline control are also outside. Only the decoded computation and its flags live here.

Top module: `xs_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res`, `ovf_trap`, `bad_func` and `wr_en` are all cleared to zero at that edge.
- R2: The outputs are registered. Inputs present before a rising edge appear on the outputs after that edge and stay unchanged until the next edge.
- R3: With `op_major`=000000 and `op_func`=000011, `res` is `src_t` shifted right by `shamt`, and the vacated upper bits are filled with `src_t[31]`.
- R4: With `op_major`=000000 and `op_func`=000111 (sign fill) or 000110 (zero fill), `src_t` is shifted right by `src_s[4:0]`. Bits 31..5 of `src_s` and the `shamt` field have no effect.
- R5: With `op_major`=000000 and `op_func`=000010, `res` is `src_t` shifted right by `shamt`, and the vacated upper bits are filled with zeros.
- R6: With `op_major`=000000 and `op_func`=100010, `res` = `src_s` − `src_t` modulo 2^32. `ovf_trap` is 1 exactly when the operand signs differ and the sign of `res` differs from `src_s[31]`. In that case `res` still carries the difference and `wr_en` is 0.
- R7: With `op_major`=000000 and `op_func`=100011, `res` = `src_s` − `src_t` modulo 2^32, and `ovf_trap` is 0 for every operand pair.
- R8: With `op_major`=000000 and `op_func`=100110, `res` = `src_s` XOR `src_t`.
- R9: With `op_major`=001110, `res` = `src_s` XOR {16'h0000, `imm`}. In this case `op_func` has no effect.
- R10: Any other function code under `op_major`=000000, and any `op_major` other than 000000 or 001110, sets `bad_func`=1, `res`=0, `ovf_trap`=0 and `wr_en`=0.
- R11: `wr_en` is 1 for every legal operation that does not raise `ovf_trap`.
- R12: `ovf_trap` and `bad_func` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_major | input | 6 | Primary opcode |
| op_func | input | 6 | Function field of register-format instructions |
| src_s | input | 32 | First source operand (minuend, variable shift amount) |
| src_t | input | 32 | Second source operand (subtrahend, shifted value) |
| shamt | input | 5 | Constant shift amount |
| imm | input | 16 | Immediate for the exclusive-OR form |
| res | output | 32 | Registered result |
| ovf_trap | output | 1 | Signed-subtract overflow exception |
| bad_func | output | 1 | Unimplemented encoding |
| wr_en | output | 1 | Result may be written back |

## Verification
The bench aims at the following corner cases:
- Shifts of a negative value by 31 and by 0. A wrong fill gives 0x00000001 instead of all ones, or the value changes when the shift amount is zero.
- Variable shifts whose `src_s` has garbage in bits 31..5. A unit that uses too many bits of the amount returns zero or a wrongly shifted value.
- Subtractions at the two overflow edges (most negative minus one, and zero minus the most negative value), run as both subtract forms. A swapped trap enable, or an overflow rule based on the wrong sign, shows up as a missing or spurious `ovf_trap` or a high `wr_en`.
- The immediate exclusive-OR with bit 15 set, where sign extension would flip the upper half.
- Unlisted codes, which must come back as zero with `bad_func` set.

// File: rtl/xs_pkg.sv
package xs_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] MAJ_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] MAJ_XORI  = 6'b001110;

  localparam logic [OPC_W-1:0] FN_SRL_C  = 6'b000010;
  localparam logic [OPC_W-1:0] FN_SRA_C  = 6'b000011;
  localparam logic [OPC_W-1:0] FN_SRL_V  = 6'b000110;
  localparam logic [OPC_W-1:0] FN_SRA_V  = 6'b000111;
  localparam logic [OPC_W-1:0] FN_SUB_T  = 6'b100010;
  localparam logic [OPC_W-1:0] FN_SUB_N  = 6'b100011;
  localparam logic [OPC_W-1:0] FN_XOR_R  = 6'b100110;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_SHIFT = 2'd1,
    K_SUB   = 2'd2,
    K_XOR   = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  arith;    // sign fill for shifts
    logic  var_amt;  // amount from first source operand
    logic  trap_en;  // overflow raises exception
    logic  use_imm;  // second XOR operand is the immediate
    logic  illegal;
  } dec_t;

endpackage

// File: rtl/xs_decode.sv
module xs_decode
  import xs_pkg::*;
(
  input  logic [OPC_W-1:0] major,
  input  logic [OPC_W-1:0] func,
  output dec_t             dec
);

  always_comb begin
    dec = '{kind: K_NONE, arith: 1'b0, var_amt: 1'b0,
            trap_en: 1'b0, use_imm: 1'b0, illegal: 1'b1};
    if (major == MAJ_XORI) begin
      dec.kind    = K_XOR;
      dec.use_imm = 1'b1;
      dec.illegal = 1'b0;
    end else if (major == MAJ_REG) begin
      dec.illegal = 1'b0;
      case (func)
        FN_SRL_C: dec.kind = K_SHIFT;
        FN_SRA_C: begin dec.kind = K_SHIFT; dec.arith = 1'b1; end
        FN_SRL_V: begin dec.kind = K_SHIFT; dec.var_amt = 1'b1; end
        FN_SRA_V: begin
          dec.kind    = K_SHIFT;
          dec.arith   = 1'b1;
          dec.var_amt = 1'b1;
        end
        FN_SUB_T: begin dec.kind = K_SUB; dec.trap_en = 1'b1; end
        FN_SUB_N: dec.kind = K_SUB;
        FN_XOR_R: dec.kind = K_XOR;
        default:  dec.illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/xs_shift.sv
module xs_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  input  logic [SH_W-1:0]   amt,
  input  logic              arith,
  output logic [DATA_W-1:0] out
);

  logic              fill;
  logic [DATA_W-1:0] st [SH_W+1];

  assign fill  = arith & val[DATA_W-1];
  assign st[0] = val;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign st[i+1] = amt[i]
      ? { {STEP{fill}}, st[i][DATA_W-1:STEP] }
      : st[i];
  end

  assign out = st[SH_W];

  // R3/R5: a zero shift amount passes the value unchanged
  always_comb begin
    if (amt == '0) begin
      a_r3_zero_shift_identity: assert (out == val);
    end
  end

endmodule

// File: rtl/xs_sub.sv
module xs_sub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] diff,
  output logic              ovf
);

  localparam int MSB = DATA_W - 1;

  assign diff = a - b;
  assign ovf  = (a[MSB] ^ b[MSB]) & (diff[MSB] ^ a[MSB]);

  // R6: operands of equal sign can never overflow on subtraction
  always_comb begin
    if (a[MSB] == b[MSB]) begin
      a_r6_same_sign_no_ovf: assert (!ovf);
    end
  end

endmodule

// File: rtl/xs_exec_unit.sv
module xs_exec_unit
  import xs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [5:0]                 op_major,
  input  logic [5:0]                 op_func,
  input  logic [DATA_W-1:0]          src_s,
  input  logic [DATA_W-1:0]          src_t,
  input  logic [$clog2(DATA_W)-1:0]  shamt,
  input  logic [IMM_W-1:0]           imm,
  output logic [DATA_W-1:0]          res,
  output logic                       ovf_trap,
  output logic                       bad_func,
  output logic                       wr_en
);

  localparam int SH_W = $clog2(DATA_W);

  dec_t              dec;
  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] sh_out, sub_out, xor_b, nxt_res;
  logic              sub_ovf, nxt_ovf;

  xs_decode u_dec (
    .major (op_major),
    .func  (op_func),
    .dec   (dec)
  );

  assign amt = dec.var_amt ? src_s[SH_W-1:0] : shamt;

  xs_shift #(.DATA_W(DATA_W)) u_shift (
    .val   (src_t),
    .amt   (amt),
    .arith (dec.arith),
    .out   (sh_out)
  );

  xs_sub #(.DATA_W(DATA_W)) u_sub (
    .a    (src_s),
    .b    (src_t),
    .diff (sub_out),
    .ovf  (sub_ovf)
  );

  assign xor_b = dec.use_imm ? {{(DATA_W-IMM_W){1'b0}}, imm} : src_t;

  always_comb begin
    nxt_res = '0;
    nxt_ovf = 1'b0;
    if (!dec.illegal) begin
      case (dec.kind)
        K_SHIFT: nxt_res = sh_out;
        K_SUB: begin
          nxt_res = sub_out;
          nxt_ovf = dec.trap_en & sub_ovf;
        end
        K_XOR:   nxt_res = src_s ^ xor_b;
        default: nxt_res = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res      <= '0;
      ovf_trap <= 1'b0;
      bad_func <= 1'b0;
      wr_en    <= 1'b0;
    end else begin
      res      <= nxt_res;
      ovf_trap <= nxt_ovf;
      bad_func <= dec.illegal;
      wr_en    <= ~(nxt_ovf | dec.illegal);
    end
  end

  // R12: the two exception flags are exclusive
  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_trap, bad_func}));

  // R6: a trapped result is never written
  a_r6_trap_blocks_write: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> !wr_en);

  // R10: an unimplemented encoding yields a zero result
  a_r10_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    bad_func |-> (res == '0 && !wr_en));

  // R7: the non-trapping subtract never raises the trap
  a_r7_no_trap_unsigned: assert property (@(posedge clk) disable iff (rst)
    (op_major == MAJ_REG && op_func == FN_SUB_N) |=> !ovf_trap);

  // R9: immediate XOR leaves the upper half of the first operand intact
  a_r9_imm_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (op_major == MAJ_XORI) |=> res[DATA_W-1:IMM_W] == $past(src_s[DATA_W-1:IMM_W]));

endmodule

// File: tb/sim_xs_exec_unit.sv
module sim_xs_exec_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  op_major = '0;
  logic [5:0]  op_func  = '0;
  logic [31:0] src_s = '0, src_t = '0;
  logic [4:0]  shamt = '0;
  logic [15:0] imm = '0;
  logic [31:0] res;
  logic        ovf_trap, bad_func, wr_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  xs_exec_unit u0 (
    .clk(clk), .rst(rst), .op_major(op_major), .op_func(op_func),
    .src_s(src_s), .src_t(src_t), .shamt(shamt), .imm(imm),
    .res(res), .ovf_trap(ovf_trap), .bad_func(bad_func), .wr_en(wr_en)
  );

  typedef struct packed {
    logic [31:0] r;
    logic        o;
    logic        b;
    logic        w;
  } exp_t;

  function automatic exp_t model(logic [5:0] mj, logic [5:0] fn,
                                 logic [31:0] s, logic [31:0] t,
                                 logic [4:0] sa, logic [15:0] im);
    exp_t e;
    logic [31:0] d;
    e = '{r: 32'h0, o: 1'b0, b: 1'b0, w: 1'b1};
    if (mj == 6'b001110) e.r = s ^ {16'h0, im};
    else if (mj != 6'b000000) begin e.b = 1'b1; e.w = 1'b0; end
    else begin
      case (fn)
        6'b000010: e.r = t >> sa;
        6'b000011: e.r = 32'($signed(t) >>> sa);
        6'b000110: e.r = t >> s[4:0];
        6'b000111: e.r = 32'($signed(t) >>> s[4:0]);
        6'b100011: e.r = s - t;
        6'b100010: begin
          d   = s - t;
          e.r = d;
          e.o = ($signed(s) < 0) != ($signed(t) < 0) && (d[31] != s[31]);
          e.w = ~e.o;
        end
        6'b100110: e.r = s ^ t;
        default: begin e.b = 1'b1; e.w = 1'b0; end
      endcase
    end
    return e;
  endfunction

  function automatic string tag(logic [5:0] mj, logic [5:0] fn);
    if (mj == 6'b001110) return "R9";
    if (mj != 6'b000000) return "R10";
    case (fn)
      6'b000011: return "R3";
      6'b000111, 6'b000110: return "R4";
      6'b000010: return "R5";
      6'b100010: return "R6";
      6'b100011: return "R7";
      6'b100110: return "R8";
      default:   return "R10";
    endcase
  endfunction

  task automatic compare(string req, exp_t e);
    n_chk++;
    if (res !== e.r || ovf_trap !== e.o || bad_func !== e.b || wr_en !== e.w) begin
      n_bad++;
      $display("FAIL %s: got res=%h ovf=%b bad=%b we=%b, expected res=%h ovf=%b bad=%b we=%b",
               req, res, ovf_trap, bad_func, wr_en, e.r, e.o, e.b, e.w);
    end
  endtask

  task automatic apply(logic [5:0] mj, logic [5:0] fn, logic [31:0] s,
                       logic [31:0] t, logic [4:0] sa, logic [15:0] im);
    @(negedge clk);
    op_major = mj; op_func = fn; src_s = s; src_t = t; shamt = sa; imm = im;
    @(negedge clk);
    compare(tag(mj, fn), model(mj, fn, s, t, sa, im));
    // R11 and R12 covered by the expected write enable and flags
  endtask

  localparam logic [5:0] LEGAL [7] = '{6'b000010, 6'b000011, 6'b000110,
                                       6'b000111, 6'b100010, 6'b100011, 6'b100110};

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t zero_e;
    void'($urandom(32'h5eed_1234));
    zero_e = '{r: 32'h0, o: 1'b0, b: 1'b0, w: 1'b0};
    repeat (3) @(negedge clk);
    compare("R1", zero_e);
    rst = 1'b0;

    // Directed corners
    apply(6'b000000, 6'b000011, 32'h0, 32'h8000_0000, 5'd31, 16'h0);   // R3 full sign fill
    apply(6'b000000, 6'b000011, 32'h0, 32'h9234_5678, 5'd0,  16'h0);   // R3 zero shift
    apply(6'b000000, 6'b000010, 32'h0, 32'h8000_0000, 5'd31, 16'h0);   // R5 zero fill
    apply(6'b000000, 6'b000111, 32'hFFFF_FFE4, 32'hF000_0000, 5'd9, 16'h0); // R4 upper Rs ignored
    apply(6'b000000, 6'b000110, 32'hABCD_EF20, 32'hF000_0000, 5'd7, 16'h0); // R4 low bits zero
    apply(6'b000000, 6'b100010, 32'h8000_0000, 32'h1, 5'd0, 16'h0);    // R6 overflow
    apply(6'b000000, 6'b100010, 32'h0, 32'h8000_0000, 5'd0, 16'h0);    // R6 overflow
    apply(6'b000000, 6'b100010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 16'h0); // R6 overflow
    apply(6'b000000, 6'b100010, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 5'd0, 16'h0); // R6 no overflow edge
    apply(6'b000000, 6'b100011, 32'h8000_0000, 32'h1, 5'd0, 16'h0);    // R7 no trap
    apply(6'b000000, 6'b100110, 32'hA5A5_A5A5, 32'hFFFF_0000, 5'd0, 16'h0); // R8
    apply(6'b001110, 6'b111111, 32'h1234_5678, 32'h0, 5'd0, 16'h8001); // R9 zero extend
    apply(6'b000000, 6'b100000, 32'h1, 32'h2, 5'd3, 16'h0);            // R10 bad func
    apply(6'b001000, 6'b100110, 32'h1, 32'h2, 5'd3, 16'h0);            // R10 bad major

    // R2: outputs hold until the next rising edge
    @(negedge clk);
    op_major = 6'b000000; op_func = 6'b100110; src_s = 32'hFFFF_FFFF; src_t = 32'h0;
    #1;
    compare("R2", model(6'b001000, 6'b100110, 32'h1, 32'h2, 5'd3, 16'h0));
    @(negedge clk);
    compare("R2", model(6'b000000, 6'b100110, 32'hFFFF_FFFF, 32'h0, 5'd3, 16'h0));

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [5:0] mj, fn;
      int pick;
      pick = $urandom_range(0, 9);
      mj = (pick < 7) ? 6'b000000 : (pick < 9 ? 6'b001110 : 6'($urandom));
      fn = ($urandom_range(0, 7) == 0) ? 6'($urandom) : LEGAL[$urandom_range(0, 6)];
      apply(mj, fn, $urandom, $urandom, 5'($urandom), 16'($urandom));
    end

    // R1: reset in mid-stream clears the outputs again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    compare("R1", zero_e);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule